// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Bank

This block is the byte-wide register file through which host software steers an Ethernet MAC and observes its state. A simple host bus (address, write strobe, read strobe, 8-bit write data, combinational 8-bit read data) reaches three registers: a network control register, a network status register and a transmit control register. The control fields drive the MAC and PHY datapath directly as output pins. The status fields mix live read-only inputs from the PHY and receive FIFO with sticky event flags.

Hardware event pulses (transmit completion for packet slot 1 and slot 2, wakeup detection) set sticky flags. Software clears these flags either by reading the status register or by writing 1 to the flag's bit. Writing 1 to the reset bit of the control register starts a software reset window that lasts a parameterised number of clock cycles. The window clears every control field except the PHY select, the wakeup enable and the wakeup status, and it is exported on `soft_reset_active` so that neighbouring logic can follow it.

Top module: `mac_csr_bank`

## Requirements
- R1: Register map: control at address 0, status at address 1, transmit control at address 2, and any other address reads 0. Control bits are [7] external-PHY select, [6] wakeup enable, [4] force collision, [3] full duplex, [2:1] loopback, [0] reset busy. Status bits are [7] speed (1 = 10 Mb/s), [6] link up, [5] wakeup event, [3] slot 2 sent, [2] slot 1 sent, [1] RX FIFO overflow. Transmit control bits are [6] jabber timer off, [5] keep retrying after excessive collisions, [4] slot 2 pad off, [3] slot 2 CRC off. All other bits read 0.
- R2: Writable control and transmit control fields appear on their output pins after the write edge. The loopback pins carry the written code: 00 normal, 01 MAC internal, 10 PHY 100M digital, 11 reserved.
- R3: A write with control bit 0 set, made while no reset is running, raises `soft_reset_active` and control bit 0 for exactly RST_CYCLES cycles. Both then drop by themselves.
- R4: The software reset clears force collision, full duplex, loopback, all transmit control fields and both transmit-done flags. It keeps PHY select, wakeup enable and wakeup status. Writes to the control and transmit control registers are ignored while the window runs.
- R5: Full duplex can be written only while the external PHY is already selected. With the internal PHY selected, the bit and the `full_duplex` pin follow `phy_full_duplex`.
- R6: A one-cycle pulse on `tx1_done`, `tx2_done` or (with wakeup enabled) `wake_event` sets its status flag, and the flag stays set until cleared.
- R7: A read of the status register returns the flags as they stand and clears all three sticky flags at that edge.
- R8: Writing 1 to status bit 5, 3 or 2 clears that flag. Writing 0 leaves it unchanged.
- R9: An event pulse in the same cycle as a read-clear or write-1-clear of its flag leaves the flag set.
- R10: Clearing the wakeup enable clears the wakeup status. Wakeup events are not recorded while the enable is 0.
- R11: Speed, link and RX overflow status bits follow their inputs, and writes to the status register do not change them.
- R12: After hardware reset every register field, flag and output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (triggers read-clear) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| phy_speed_10 | input | 1 | PHY reports 10 Mb/s |
| phy_link_up | input | 1 | PHY reports link up |
| phy_full_duplex | input | 1 | PHY-reported duplex |
| rx_fifo_ovf | input | 1 | RX FIFO overflow level |
| tx1_done | input | 1 | Slot 1 transmit complete pulse |
| tx2_done | input | 1 | Slot 2 transmit complete pulse |
| wake_event | input | 1 | Wakeup detected pulse |
| ext_phy_sel | output | 1 | External PHY selected |
| wake_en | output | 1 | Wakeup function enabled |
| force_collision | output | 1 | Force collision test mode |
| full_duplex | output | 1 | Effective duplex mode |
| loopback_mode | output | 2 | Loopback code |
| jabber_dis | output | 1 | Jabber timer disabled |
| excess_col_retry | output | 1 | Keep retrying after excessive collisions |
| pad_dis_slot2 | output | 1 | Pad append off for slot 2 |
| crc_dis_slot2 | output | 1 | CRC append off for slot 2 |
| soft_reset_active | output | 1 | Software reset window |

## Verification
The bench targets same-cycle collisions between an event pulse and a read-clear or write-1-clear. A design that lets the clear win loses a transmit completion. It also tests writes of 0 to the sticky bits, which a design that treats the status register as plain read/write would wrongly clear. The software reset window is timed to the exact cycle, and the bench tries to write the control registers in the middle of it. A wrong counter shows up as a window one cycle too long or too short, and a missing write guard lets fields come back before the reset ends. Further cases cover full-duplex writes with the internal PHY selected, which must be ignored, and the wakeup enable being dropped while the status is set, which must wipe that status.

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;

    localparam int REG_W        = 8;
    localparam int NUM_TX_SLOTS = 2;

    // status bit positions that software clears by write-1
    localparam int STS_WAKE_BIT = 5;
    localparam int STS_TX1_BIT  = 2;

    typedef enum logic [1:0] {
        LB_NONE   = 2'b00,
        LB_MAC    = 2'b01,
        LB_PHY100 = 2'b10,
        LB_RSVD   = 2'b11
    } loop_mode_e;

    typedef struct packed {
        logic       ext;
        logic       wen;
        logic       fcol;
        logic       fdx;
        loop_mode_e lbk;
    } ctrl_t;

    typedef struct packed {
        logic jab_dis;
        logic exc_retry;
        logic pad_dis2;
        logic crc_dis2;
    } txctl_t;

endpackage

// File: rtl/mac_csr_reset_timer.sv
module mac_csr_reset_timer #(
    parameter int RST_CYCLES = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start && !tmr_q.busy) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(RST_CYCLES - 1);
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active = tmr_q.busy;
endmodule

// File: rtl/mac_csr_sticky_flag.sv
module mac_csr_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic force_zero,
    output logic flag
);
    logic flag_d, flag_q;

    // a new event outranks a clear; force_zero outranks both
    always_comb begin
        if (force_zero) begin
            flag_d = 1'b0;
        end else begin
            flag_d = (flag_q & ~clr) | set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/mac_csr_bank.sv
module mac_csr_bank
    import mac_csr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int RST_CYCLES = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              phy_speed_10,
    input  logic              phy_link_up,
    input  logic              phy_full_duplex,
    input  logic              rx_fifo_ovf,
    input  logic              tx1_done,
    input  logic              tx2_done,
    input  logic              wake_event,
    output logic              ext_phy_sel,
    output logic              wake_en,
    output logic              force_collision,
    output logic              full_duplex,
    output logic [1:0]        loopback_mode,
    output logic              jabber_dis,
    output logic              excess_col_retry,
    output logic              pad_dis_slot2,
    output logic              crc_dis_slot2,
    output logic              soft_reset_active
);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_TXC = ADDR_W'(2);

    typedef struct packed {
        ctrl_t  ctrl;
        txctl_t txc;
    } regs_t;

    regs_t st_d, st_q;

    logic                    srst_active;
    logic                    srst_start;
    logic                    hit_ctl, hit_sts, hit_txc;
    logic                    ctl_wr_ok, txc_wr_ok;
    logic                    sts_rd_clr;
    logic [REG_W-1:0]        w1c;
    logic [NUM_TX_SLOTS-1:0] tx_done_vec;
    logic [NUM_TX_SLOTS-1:0] tx_flags;
    logic                    wake_flag;
    logic                    fdx_eff;

    assign hit_ctl    = (addr == A_CTL);
    assign hit_sts    = (addr == A_STS);
    assign hit_txc    = (addr == A_TXC);
    assign srst_start = wr_en && hit_ctl && wdata[0] && !srst_active;
    assign ctl_wr_ok  = wr_en && hit_ctl && !srst_active;
    assign txc_wr_ok  = wr_en && hit_txc && !srst_active;
    assign sts_rd_clr = rd_en && hit_sts;
    assign w1c        = (wr_en && hit_sts) ? wdata : '0;

    // next-state of the writable control fields
    always_comb begin
        st_d = st_q;
        if (ctl_wr_ok) begin
            st_d.ctrl.ext = wdata[7];
            st_d.ctrl.wen = wdata[6];
            if (!srst_start) begin
                st_d.ctrl.fcol = wdata[4];
                st_d.ctrl.lbk  = loop_mode_e'(wdata[2:1]);
                if (st_q.ctrl.ext) begin
                    st_d.ctrl.fdx = wdata[3];
                end
            end
        end
        if (txc_wr_ok) begin
            st_d.txc.jab_dis   = wdata[6];
            st_d.txc.exc_retry = wdata[5];
            st_d.txc.pad_dis2  = wdata[4];
            st_d.txc.crc_dis2  = wdata[3];
        end
        if (srst_start || srst_active) begin
            st_d.ctrl.fcol = 1'b0;
            st_d.ctrl.fdx  = 1'b0;
            st_d.ctrl.lbk  = LB_NONE;
            st_d.txc       = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    mac_csr_reset_timer #(.RST_CYCLES(RST_CYCLES)) u_rst_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (srst_start),
        .active (srst_active)
    );

    assign tx_done_vec = {tx2_done, tx1_done};

    for (genvar gi = 0; gi < NUM_TX_SLOTS; gi++) begin : g_tx_flag
        mac_csr_sticky_flag u_flag (
            .clk        (clk),
            .rst_n      (rst_n),
            .set        (tx_done_vec[gi]),
            .clr        (sts_rd_clr | w1c[STS_TX1_BIT + gi]),
            .force_zero (srst_start | srst_active),
            .flag       (tx_flags[gi])
        );
    end

    mac_csr_sticky_flag u_wake_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (wake_event),
        .clr        (sts_rd_clr | w1c[STS_WAKE_BIT]),
        .force_zero (!st_d.ctrl.wen),
        .flag       (wake_flag)
    );

    assign fdx_eff = st_q.ctrl.ext ? st_q.ctrl.fdx : phy_full_duplex;

    always_comb begin
        unique case (1'b1)
            hit_ctl: rdata = {st_q.ctrl.ext, st_q.ctrl.wen, 1'b0, st_q.ctrl.fcol,
                              fdx_eff, st_q.ctrl.lbk, srst_active};
            hit_sts: rdata = {phy_speed_10, phy_link_up, wake_flag, 1'b0,
                              tx_flags[1], tx_flags[0], rx_fifo_ovf, 1'b0};
            hit_txc: rdata = {1'b0, st_q.txc.jab_dis, st_q.txc.exc_retry,
                              st_q.txc.pad_dis2, st_q.txc.crc_dis2, 3'b000};
            default: rdata = '0;
        endcase
    end

    assign ext_phy_sel       = st_q.ctrl.ext;
    assign wake_en           = st_q.ctrl.wen;
    assign force_collision   = st_q.ctrl.fcol;
    assign full_duplex       = fdx_eff;
    assign loopback_mode     = st_q.ctrl.lbk;
    assign jabber_dis        = st_q.txc.jab_dis;
    assign excess_col_retry  = st_q.txc.exc_retry;
    assign pad_dis_slot2     = st_q.txc.pad_dis2;
    assign crc_dis_slot2     = st_q.txc.crc_dis2;
    assign soft_reset_active = srst_active;
endmodule

// File: rtl/mac_csr_bank_checker.sv
module mac_csr_bank_checker #(
    parameter int ADDR_W     = 8,
    parameter int RST_CYCLES = 1250
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        wdata,
    input logic              tx1_done,
    input logic              ext_phy_sel,
    input logic              wake_en,
    input logic              force_collision,
    input logic [1:0]        loopback_mode,
    input logic              jabber_dis,
    input logic              excess_col_retry,
    input logic              pad_dis_slot2,
    input logic              crc_dis_slot2,
    input logic              soft_reset_active,
    input logic [1:0]        tx_flags,
    input logic              wake_flag
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (soft_reset_active) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    assert_reset_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_reset_active) |-> $past(wr_en && addr == ADDR_W'(0) && wdata[0]));

    assert_reset_not_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_active |-> run_q < RST_CYCLES);

    assert_reset_exact_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_reset_active) |-> $past(run_q) == RST_CYCLES - 1);

    assert_fields_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_active |-> (loopback_mode == 2'b00 && !force_collision && !jabber_dis &&
                               !excess_col_retry && !pad_dis_slot2 && !crc_dis_slot2 &&
                               tx_flags == 2'b00));

    assert_protected_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_active && $past(soft_reset_active) |-> $stable(ext_phy_sel) && $stable(wake_en));

    assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx1_done && !soft_reset_active && !(wr_en && addr == ADDR_W'(0) && wdata[0])
        |=> tx_flags[0]);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == ADDR_W'(1) && !tx1_done |=> !tx_flags[0]);

    assert_wake_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_en |-> !wake_flag);
endmodule

bind mac_csr_bank mac_csr_bank_checker #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .addr              (addr),
    .wr_en             (wr_en),
    .rd_en             (rd_en),
    .wdata             (wdata),
    .tx1_done          (tx1_done),
    .ext_phy_sel       (ext_phy_sel),
    .wake_en           (wake_en),
    .force_collision   (force_collision),
    .loopback_mode     (loopback_mode),
    .jabber_dis        (jabber_dis),
    .excess_col_retry  (excess_col_retry),
    .pad_dis_slot2     (pad_dis_slot2),
    .crc_dis_slot2     (crc_dis_slot2),
    .soft_reset_active (soft_reset_active),
    .tx_flags          (tx_flags),
    .wake_flag         (wake_flag)
);

// File: tb/mac_csr_bank_bench.sv
module mac_csr_bank_bench;
    localparam int ADDR_W = 8;
    localparam int RSTC   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic phy_speed_10 = 1'b0, phy_link_up = 1'b0, phy_full_duplex = 1'b0, rx_fifo_ovf = 1'b0;
    logic tx1_done = 1'b0, tx2_done = 1'b0, wake_event = 1'b0;
    logic ext_phy_sel, wake_en, force_collision, full_duplex;
    logic [1:0] loopback_mode;
    logic jabber_dis, excess_col_retry, pad_dis_slot2, crc_dis_slot2, soft_reset_active;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mac_csr_bank #(.ADDR_W(ADDR_W), .RST_CYCLES(RSTC)) u_mac_csr_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .phy_speed_10(phy_speed_10),
        .phy_link_up(phy_link_up), .phy_full_duplex(phy_full_duplex),
        .rx_fifo_ovf(rx_fifo_ovf), .tx1_done(tx1_done), .tx2_done(tx2_done),
        .wake_event(wake_event), .ext_phy_sel(ext_phy_sel), .wake_en(wake_en),
        .force_collision(force_collision), .full_duplex(full_duplex),
        .loopback_mode(loopback_mode), .jabber_dis(jabber_dis),
        .excess_col_retry(excess_col_retry), .pad_dis_slot2(pad_dis_slot2),
        .crc_dis_slot2(crc_dis_slot2), .soft_reset_active(soft_reset_active)
    );

    // reference model of the requirements
    bit m_ext, m_wen, m_fcol, m_fdx, m_jab, m_exc, m_pad, m_crc, m_tx1, m_tx2, m_wst;
    bit [1:0] m_lbk;
    int m_rc;

    function automatic void model_clear();
        {m_ext, m_wen, m_fcol, m_fdx, m_jab, m_exc, m_pad, m_crc, m_tx1, m_tx2, m_wst} = '0;
        m_lbk = 2'b00;
        m_rc  = 0;
    endfunction

    function automatic bit fdx_exp();
        return m_ext ? m_fdx : phy_full_duplex;
    endfunction

    function automatic logic [7:0] exp_read(logic [ADDR_W-1:0] a);
        case (a)
            ADDR_W'(0): return {m_ext, m_wen, 1'b0, m_fcol, fdx_exp(), m_lbk, m_rc > 0};
            ADDR_W'(1): return {phy_speed_10, phy_link_up, m_wst, 1'b0, m_tx2, m_tx1, rx_fifo_ovf, 1'b0};
            ADDR_W'(2): return {1'b0, m_jab, m_exc, m_pad, m_crc, 3'b000};
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic [11:0] exp_outs();
        return {m_ext, m_wen, m_fcol, fdx_exp(), m_lbk, m_jab, m_exc, m_pad, m_crc, m_rc > 0};
    endfunction

    function automatic void model_edge();
        bit act, wc, ws, wt, rs, start, old_ext, clr5, clr3, clr2;
        act     = m_rc > 0;
        wc      = wr_en && addr == ADDR_W'(0);
        ws      = wr_en && addr == ADDR_W'(1);
        wt      = wr_en && addr == ADDR_W'(2);
        rs      = rd_en && addr == ADDR_W'(1);
        start   = wc && wdata[0] && !act;
        old_ext = m_ext;
        if (wc && !act) begin
            m_ext = wdata[7];
            m_wen = wdata[6];
            if (!start) begin
                m_fcol = wdata[4];
                m_lbk  = wdata[2:1];
                if (old_ext) m_fdx = wdata[3];
            end
        end
        if (wt && !act) {m_jab, m_exc, m_pad, m_crc} = wdata[6:3];
        clr5 = rs || (ws && wdata[5]);
        clr3 = rs || (ws && wdata[3]);
        clr2 = rs || (ws && wdata[2]);
        if (!m_wen) m_wst = 1'b0;
        else        m_wst = (m_wst && !clr5) || wake_event;
        if (start || act) begin
            m_tx1 = 1'b0; m_tx2 = 1'b0;
            m_fcol = 1'b0; m_fdx = 1'b0; m_lbk = 2'b00;
            {m_jab, m_exc, m_pad, m_crc} = 4'b0000;
        end else begin
            m_tx1 = (m_tx1 && !clr2) || tx1_done;
            m_tx2 = (m_tx2 && !clr3) || tx2_done;
        end
        if (start)    m_rc = RSTC;
        else if (act) m_rc = m_rc - 1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called right after a negedge with inputs already set
    task automatic step(string tag);
        #2;
        check(tag, 32'(rdata), 32'(exp_read(addr)));
        check(tag, 32'(exp_outs()) ^ 32'(exp_outs()) ^
                   32'({ext_phy_sel, wake_en, force_collision, full_duplex, loopback_mode,
                        jabber_dis, excess_col_retry, pad_dis_slot2, crc_dis_slot2,
                        soft_reset_active}),
              32'(exp_outs()));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        tx1_done = 1'b0; tx2_done = 1'b0; wake_event = 1'b0;
    endtask

    task automatic wr(string tag, logic [ADDR_W-1:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step(tag);
    endtask

    task automatic rd(string tag, logic [ADDR_W-1:0] a);
        addr = a; rd_en = 1'b1;
        step(tag);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        rd("R12", 0); rd("R12", 1); rd("R12", 2);

        // R1: map, reserved bits, unused addresses
        wr("R1", 0, 8'hEE); rd("R1", 0);
        wr("R1", 2, 8'hFF); rd("R1", 2);
        rd("R1", 3); rd("R1", 8'hA5);

        // R2: loopback codes on pins
        wr("R2", 0, 8'h02); step("R2");
        wr("R2", 0, 8'h04); step("R2");
        wr("R2", 0, 8'h06); step("R2");

        // R5: duplex writable only with external PHY already selected
        phy_full_duplex = 1'b1;
        wr("R5", 0, 8'h08); rd("R5", 0);
        phy_full_duplex = 1'b0;
        wr("R5", 0, 8'h80); wr("R5", 0, 8'h88); rd("R5", 0);
        phy_full_duplex = 1'b1; step("R5");
        wr("R5", 0, 8'h00); phy_full_duplex = 1'b0; rd("R5", 0);

        // R6 / R7: sticky then read-clear
        tx1_done = 1'b1; step("R6");
        step("R6"); step("R6");
        rd("R7", 1); rd("R7", 1);

        // R8: write 0 keeps, write 1 clears
        tx2_done = 1'b1; step("R8");
        wr("R8", 1, 8'h00); addr = 1; step("R8");
        wr("R8", 1, 8'h08); addr = 1; step("R8");

        // R9: event wins over read-clear and write-1-clear
        tx1_done = 1'b1; step("R9");
        tx1_done = 1'b1; rd("R9", 1); addr = 1; step("R9");
        tx2_done = 1'b1; step("R9");
        tx2_done = 1'b1; wr("R9", 1, 8'h0C); addr = 1; step("R9");

        // R10: wakeup enable gating
        wake_event = 1'b1; addr = 1; step("R10"); addr = 1; step("R10");
        wr("R10", 0, 8'h40); wake_event = 1'b1; addr = 1; step("R10");
        addr = 1; step("R10");
        wr("R10", 0, 8'h00); addr = 1; step("R10");

        // R11: read-only inputs unaffected by writes
        phy_speed_10 = 1'b1; phy_link_up = 1'b1; rx_fifo_ovf = 1'b1;
        wr("R11", 1, 8'hFF); rd("R11", 1);
        phy_link_up = 1'b0; rd("R11", 1);

        // R3 / R4: soft reset window
        wr("R4", 0, 8'hD6); wr("R4", 2, 8'h78);
        wake_event = 1'b1; step("R4");
        wr("R3", 0, 8'hC1);
        cnt = 0;
        while (soft_reset_active === 1'b1 && cnt < 100) begin
            cnt++;
            if (cnt == 3) wr("R4", 0, 8'h16);
            else if (cnt == 4) wr("R4", 2, 8'h78);
            else if (cnt == 5) begin tx1_done = 1'b1; step("R4"); end
            else rd("R3", 0);
        end
        check("R3", 32'(cnt), 32'(RSTC));
        rd("R4", 0); rd("R4", 2); rd("R4", 1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = int'($urandom % 4);
            addr = ($urandom % 16 == 0) ? ADDR_W'($urandom) : ADDR_W'($urandom % 4);
            wdata = 8'($urandom);
            if ($urandom % 24 != 0) wdata[0] = 1'b0;
            wr_en = (op == 1);
            rd_en = (op >= 2);
            tx1_done = ($urandom % 8 == 0);
            tx2_done = ($urandom % 8 == 0);
            wake_event = ($urandom % 8 == 0);
            phy_speed_10 = 1'($urandom); phy_link_up = 1'($urandom);
            phy_full_duplex = 1'($urandom); rx_fifo_ovf = 1'($urandom);
            step("R1");
        end

        finish_run();
    end
endmodule